// File: doc/BRIEF.md
# Two-Sensor Interval Timer

The block measures the time between two sensor events. It runs from a 1 kHz clock, so each count is one millisecond. A pulse on the start sensor clears the count and sets the timer running. A pulse on the stop sensor freezes the count and raises a valid flag. The frozen value is the travel time between the two sensors. Logic downstream of the block divides the known sensor spacing by this value to get a speed.

Both sensor inputs must be single-cycle pulses that are already synchronized to the timer clock. The count is held at its maximum value rather than wrapping, and an overflow flag reports this so that a very slow transit is not read as a fast one. A start pulse always begins a new measurement. A stop pulse counts only while a measurement is running. When both pulses land in the same running cycle, the stop is applied first and the restart follows one cycle later.

Top module: `transit_timer`

## Requirements
- R1: While rst_ni is low, and after it is released, elapsed_o is 0, valid_o is 0 and ovf_o is 0 until the first start pulse.
- R2: A start pulse alone makes elapsed_o 0 after the next clock edge. Each later edge with no sensor pulse adds one to elapsed_o.
- R3: A stop pulse while running freezes elapsed_o at the value it had before that edge, and valid_o is 1 after that edge.
- R4: Once valid_o is 1, it stays 1 and elapsed_o stays unchanged until the next start pulse. Further stop pulses have no effect.
- R5: A start pulse while running or while holding a result makes elapsed_o 0 and valid_o 0 after the next edge, and counting restarts.
- R6: A start and a stop pulse in the same cycle while running first give one cycle with valid_o 1 and the frozen count. On the following edge valid_o goes to 0 and elapsed_o to 0, and counting resumes.
- R7: While running, elapsed_o stops at 2^CNT_W-1 and ovf_o goes to 1 on the edge at which a further increment was due. Only a start pulse clears ovf_o.
- R8: A stop pulse before any start pulse has no effect: valid_o stays 0 and elapsed_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 1 kHz timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sens_a_i | input | 1 | Start sensor pulse, one cycle |
| sens_b_i | input | 1 | Stop sensor pulse, one cycle |
| elapsed_o | output | CNT_W | Count of elapsed milliseconds |
| valid_o | output | 1 | The frozen result is available |
| ovf_o | output | 1 | The count saturated during this measurement |

## Verification
Most control faults show at the ports within one clock edge. A wrong state decode makes elapsed_o step when it should hold, or hold when it should step, on the very next edge. It can also make valid_o disagree with the sensor history. A fault in the deferred restart after a simultaneous start and stop shows as valid_o lasting zero cycles or more than one. Saturation faults show only when a run passes the limit, so the bench drives one run well past 2^CNT_W-1.

// File: rtl/transit_timer_pkg.sv
package transit_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/transit_timer_ctrl.sv
module transit_timer_ctrl
  import transit_timer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   stop_i,
  output logic   clr_o,
  output logic   inc_o,
  output state_e state_o,
  output logic   pend_o
);
  state_e state_q, state_d;
  logic   pend_q, pend_d;
  logic   running, do_stop, do_restart;

  assign running    = (state_q == ST_RUN);
  assign do_stop    = running & stop_i;
  // deferred restart from a coincident start/stop, or a plain start
  assign do_restart = pend_q | (start_i & ~do_stop);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    if (do_stop) begin
      state_d = ST_DONE;
      pend_d  = start_i;
    end else if (do_restart) begin
      state_d = ST_RUN;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign clr_o   = do_restart & ~do_stop;
  assign inc_o   = running & ~do_stop & ~do_restart;
  assign state_o = state_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/transit_timer_cnt.sv
module transit_timer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      if (at_max) ovf_q <= 1'b1;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/transit_timer.sv
module transit_timer
  import transit_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sens_a_i,
  input  logic             sens_b_i,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             valid_o,
  output logic             ovf_o
);
  logic   clr, inc;
  state_e ctrl_state;
  logic   ctrl_pend;

  transit_timer_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sens_a_i),
    .stop_i  (sens_b_i),
    .clr_o   (clr),
    .inc_o   (inc),
    .state_o (ctrl_state),
    .pend_o  (ctrl_pend)
  );

  transit_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .cnt_o  (elapsed_o),
    .ovf_o  (ovf_o)
  );

  assign valid_o = (ctrl_state == ST_DONE);
endmodule

// File: rtl/transit_timer_chk.sv
module transit_timer_chk
  import transit_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sens_a_i,
  input logic             sens_b_i,
  input logic [CNT_W-1:0] elapsed_o,
  input logic             valid_o,
  input logic             ovf_o,
  input state_e           state_i,
  input logic             pend_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (elapsed_o == '0 && !valid_o && !ovf_o); // R1
  end

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && !sens_a_i && !sens_b_i && elapsed_o != CNT_MAX)
    |=> elapsed_o == CNT_W'($past(elapsed_o) + 1'b1)); // R2

  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && sens_b_i) |=> valid_o && $stable(elapsed_o)); // R3

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pend_i && !sens_a_i) |=> valid_o && $stable(elapsed_o)); // R4

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sens_a_i && !sens_b_i) |=> elapsed_o == '0 && !valid_o && !ovf_o); // R5

  AST_COINCIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && sens_a_i && sens_b_i)
    |=> valid_o ##1 (!valid_o && elapsed_o == '0)); // R6

  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && !sens_a_i && !sens_b_i && elapsed_o == CNT_MAX)
    |=> elapsed_o == CNT_MAX && ovf_o); // R7

  AST_IDLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && sens_b_i && !sens_a_i) |=> !valid_o && elapsed_o == '0); // R8
endmodule

bind transit_timer transit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sens_a_i  (sens_a_i),
  .sens_b_i  (sens_b_i),
  .elapsed_o (elapsed_o),
  .valid_o   (valid_o),
  .ovf_o     (ovf_o),
  .state_i   (ctrl_state),
  .pend_i    (ctrl_pend)
);

// File: tb/transit_timer_tb_top.sv
module transit_timer_tb_top;
  localparam int CNT_W = 6;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             a = 1'b0, b = 1'b0;
  logic [CNT_W-1:0] elapsed;
  logic             valid, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model: 0 idle, 1 running, 2 holding
  int m_st = 0, m_cnt = 0, m_pend = 0;
  bit m_ovf = 1'b0;

  always #4 clk = ~clk;

  transit_timer #(.CNT_W(CNT_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sens_a_i  (a),
    .sens_b_i  (b),
    .elapsed_o (elapsed),
    .valid_o   (valid),
    .ovf_o     (ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pend = 0; m_ovf = 1'b0;
    end else if (m_st == 1 && b) begin
      m_st = 2; m_pend = a;
    end else if (m_pend != 0 || a) begin
      m_st = 1; m_cnt = 0; m_ovf = 1'b0; m_pend = 0;
    end else if (m_st == 1) begin
      if (m_cnt == MAXV) m_ovf = 1'b1;
      else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 elapsed vs model", int'(elapsed), m_cnt);
      check("R4 valid vs model", int'(valid), int'(m_st == 2));
      check("R7 ovf vs model", int'(ovf), int'(m_ovf));
    end
  end

  task automatic pulse(input logic pa, input logic pb);
    a = pa; b = pb;
    @(negedge clk);
    a = 1'b0; b = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    check("R1 elapsed in reset", int'(elapsed), 0);
    check("R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 ovf after reset", int'(ovf), 0);
    pulse(1'b0, 1'b1);
    idle(1);
    check("R8 valid after early stop", int'(valid), 0);
    check("R8 elapsed after early stop", int'(elapsed), 0);
    pulse(1'b1, 1'b0);
    check("R2 cleared on start", int'(elapsed), 0);
    idle(5);
    check("R2 counted five", int'(elapsed), 5);
    pulse(1'b0, 1'b1);
    check("R3 frozen value", int'(elapsed), 5);
    check("R3 valid set", int'(valid), 1);
    idle(4);
    pulse(1'b0, 1'b1);
    check("R4 held value", int'(elapsed), 5);
    check("R4 valid held", int'(valid), 1);
    pulse(1'b1, 1'b0);
    check("R5 restart from hold", int'(elapsed), 0);
    check("R5 valid dropped", int'(valid), 0);
    idle(3);
    pulse(1'b1, 1'b0);
    check("R5 restart while running", int'(elapsed), 0);
    idle(2);
    pulse(1'b1, 1'b1);
    check("R6 stop first valid", int'(valid), 1);
    check("R6 stop first value", int'(elapsed), 2);
    idle(1);
    check("R6 restart next valid", int'(valid), 0);
    check("R6 restart next value", int'(elapsed), 0);
    idle(3);
    check("R6 counting resumed", int'(elapsed), 3);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    check("R5 coincident in hold restarts", int'(elapsed), 0);
    idle(MAXV);
    check("R7 reached max", int'(elapsed), MAXV);
    check("R7 no ovf yet", int'(ovf), 0);
    idle(5);
    check("R7 saturated", int'(elapsed), MAXV);
    check("R7 ovf set", int'(ovf), 1);
    pulse(1'b0, 1'b1);
    check("R7 ovf kept on stop", int'(ovf), 1);
    pulse(1'b1, 1'b0);
    check("R7 ovf cleared by start", int'(ovf), 0);
    idle(2);
    finish_run();
  end
endmodule